// File: doc/BRIEF.md
# Message Rendezvous Tag-Match Engine

This engine sits at the receiving side of a node and pairs two kinds of announcements. The local processor posts receives. Each one names a sender (or any sender), a tag and the address of the buffer that will take the data. The network delivers send-ready requests. Each one names the sender, a tag and the length of the message waiting at that sender. When the two agree on tag and sender, the engine emits a message on its outbound port. That message carries the buffer address and the length, so a data mover outside the block can run the bulk transfer.

The outbound message depends on which side arrived first. A send-ready request that finds a waiting receive gets an immediate ready reply. A send-ready request that finds nothing is stored, and the sender gets a "held" notice so it can go back to computing. A receive posted later that finds such a stored request makes the engine pull the data: it issues a ready request to that sender. Both stores are kept in arrival order, so equal candidates pair first in, first out. When a store is full, the request is refused and nothing is overwritten.

Top module: `rdv_engine`

## Requirements
- R1: A send-ready request that matches a stored receive produces, one cycle later, `out_valid` with `out_code`=0 (ready reply). The other fields are: `out_node` = request source, `out_tag` = request tag, `out_addr` = the receive's buffer address, `out_len` = request length. The receive is removed from the store.
- R2: A send-ready request with no matching receive, while the pending store has room, is stored. One cycle later it produces `out_code`=1 (held), with `out_node`, `out_tag` and `out_len` taken from the request and `out_addr`=0.
- R3: A posted receive that matches a stored send-ready produces, one cycle later, `out_code`=2 (pull request) with `post_code`=1 (matched). The other fields are: `out_node` = stored source, `out_tag` = stored tag, `out_addr` = posted address, `out_len` = stored length. The stored entry is removed.
- R4: A posted receive with no match, while the receive store has room, is stored. One cycle later it produces `post_done` with `post_code`=0 (queued) and no outbound message.
- R5: A receive marked wildcard matches any source with an equal tag. This holds both when it is posted and while it waits in the store. A receive that is not wildcard needs both source and tag to be equal.
- R6: When several stored entries match, the one stored earliest is used.
- R7: A post that misses while 8 receives are stored gets `post_code`=2 (busy). A send-ready request that misses while 8 sends are pending gets `sr_busy` one cycle later. In both cases no store changes.
- R8: When a post and a send-ready request arrive in the same cycle, the post is handled normally and the send-ready request is refused with `sr_busy`.
- R9: A matched entry leaves its store in the cycle its outbound message is registered. Its slot is therefore free for the next request, and the entry never matches again.
- R10: After reset both stores are empty and `out_valid`, `post_done` and `sr_busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| post_valid | input | 1 | Receive post this cycle |
| post_wild | input | 1 | Receive accepts any source |
| post_src | input | SRC_W | Expected source node |
| post_tag | input | TAG_W | Expected tag |
| post_addr | input | ADDR_W | Destination buffer address |
| post_done | output | 1 | Post result valid |
| post_code | output | 2 | 0 queued, 1 matched, 2 busy |
| sr_valid | input | 1 | Send-ready request this cycle |
| sr_src | input | SRC_W | Requesting source node |
| sr_tag | input | TAG_W | Message tag |
| sr_len | input | LEN_W | Message length |
| sr_busy | output | 1 | Send-ready request refused |
| out_valid | output | 1 | Outbound message valid |
| out_code | output | 2 | 0 ready reply, 1 held, 2 pull request |
| out_node | output | SRC_W | Node the message goes to |
| out_tag | output | TAG_W | Tag of the pair |
| out_addr | output | ADDR_W | Receive buffer address |
| out_len | output | LEN_W | Transfer length |

## Verification
The clocked checks assume that the valid strobes never carry X once reset is released. They also assume that a refused request is offered again only as a fresh request, never as a held level. The bench drives every input at the falling edge from one sequential process, so each request lasts exactly one cycle. It keeps sources and tags in a four-value range, which makes repeat matches, wildcard hits and full stores frequent. Same-cycle post and send-ready pairs are produced on purpose to reach the refusal rule.

// File: rtl/rdv_pkg.sv
package rdv_pkg;
  typedef enum logic [1:0] {
    OUT_REPLY = 2'd0,
    OUT_HELD  = 2'd1,
    OUT_PULL  = 2'd2
  } rdv_out_e;

  typedef enum logic [1:0] {
    PST_QUEUED  = 2'd0,
    PST_MATCHED = 2'd1,
    PST_BUSY    = 2'd2
  } rdv_post_e;
endpackage

// File: rtl/rdv_table.sv
module rdv_table #(
  parameter int EW    = 8,
  parameter int DEPTH = 8,
  localparam int IW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [EW-1:0] push_data,
  input  logic          pop,
  input  logic [IW-1:0] pop_idx,
  output logic [EW-1:0] ent [DEPTH],
  output logic [CW-1:0] count,
  output logic          full
);
  logic [EW-1:0] mem [DEPTH];

  assign full = (count == CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (pop) begin
      // compact: entries above the freed slot move down, age order kept
      for (int i = 0; i < DEPTH - 1; i++)
        if (IW'(i) >= pop_idx) mem[i] <= mem[i + 1];
      mem[DEPTH-1] <= '0;
      count <= count - CW'(1);
    end else if (push) begin
      for (int i = 0; i < DEPTH; i++)
        if (CW'(i) == count) mem[i] <= push_data;
      count <= count + CW'(1);
    end
  end

  always_comb
    for (int i = 0; i < DEPTH; i++) ent[i] = mem[i];

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  p_one_op_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pop));
  p_pop_live_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (CW'(pop_idx) < count));
  p_count_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (count == $past(count) + CW'(1)));
  p_count_down_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> (count == $past(count) - CW'(1)));
endmodule

// File: rtl/rdv_pick.sv
module rdv_pick #(
  parameter int DEPTH = 8,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEPTH-1:0] hit,
  output logic             found,
  output logic [IW-1:0]    idx
);
  logic [DEPTH-1:0] below;

  always_comb begin
    found = |hit;
    idx   = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (hit[i]) idx = IW'(i);
  end

  assign below = hit & ((DEPTH'(1) << idx) - DEPTH'(1));

  p_oldest_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> (hit[idx] && below == '0));
endmodule

// File: rtl/rdv_engine.sv
module rdv_engine
  import rdv_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int SRC_W  = 4,
  parameter int TAG_W  = 8,
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              post_valid,
  input  logic              post_wild,
  input  logic [SRC_W-1:0]  post_src,
  input  logic [TAG_W-1:0]  post_tag,
  input  logic [ADDR_W-1:0] post_addr,
  output logic              post_done,
  output logic [1:0]        post_code,
  input  logic              sr_valid,
  input  logic [SRC_W-1:0]  sr_src,
  input  logic [TAG_W-1:0]  sr_tag,
  input  logic [LEN_W-1:0]  sr_len,
  output logic              sr_busy,
  output logic              out_valid,
  output logic [1:0]        out_code,
  output logic [SRC_W-1:0]  out_node,
  output logic [TAG_W-1:0]  out_tag,
  output logic [ADDR_W-1:0] out_addr,
  output logic [LEN_W-1:0]  out_len
);
  localparam int IW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  typedef struct packed {
    logic              wild;
    logic [SRC_W-1:0]  src;
    logic [TAG_W-1:0]  tag;
    logic [ADDR_W-1:0] addr;
  } rx_t;

  typedef struct packed {
    logic [SRC_W-1:0] src;
    logic [TAG_W-1:0] tag;
    logic [LEN_W-1:0] len;
  } pd_t;

  localparam int RX_W = $bits(rx_t);
  localparam int PD_W = $bits(pd_t);

  function automatic logic key_eq(input logic any_src,
                                  input logic [SRC_W-1:0] sa, input logic [SRC_W-1:0] sb,
                                  input logic [TAG_W-1:0] ta, input logic [TAG_W-1:0] tb);
    return (ta == tb) && (any_src || sa == sb);
  endfunction

  logic [RX_W-1:0]  rx_raw [DEPTH];
  logic [PD_W-1:0]  pd_raw [DEPTH];
  rx_t              rx_e   [DEPTH];
  pd_t              pd_e   [DEPTH];
  logic [CW-1:0]    rx_cnt, pd_cnt;
  logic             rx_full, pd_full;
  logic [DEPTH-1:0] rx_hit, pd_hit;
  logic             rx_found, pd_found;
  logic [IW-1:0]    rx_idx, pd_idx;

  // named events, brought out for the assertions
  logic sr_take, ev_reply, ev_hold, ev_sr_busy;
  logic ev_pull, ev_queue, ev_post_busy;

  for (genvar i = 0; i < DEPTH; i++) begin : g_view
    assign rx_e[i]   = rx_t'(rx_raw[i]);
    assign pd_e[i]   = pd_t'(pd_raw[i]);
    assign rx_hit[i] = (CW'(i) < rx_cnt) &&
                       key_eq(rx_e[i].wild, rx_e[i].src, sr_src, rx_e[i].tag, sr_tag);
    assign pd_hit[i] = (CW'(i) < pd_cnt) &&
                       key_eq(post_wild, pd_e[i].src, post_src, pd_e[i].tag, post_tag);
  end

  rdv_pick #(.DEPTH(DEPTH)) u_rx_pick (
    .clk(clk), .rst_n(rst_n), .hit(rx_hit), .found(rx_found), .idx(rx_idx));
  rdv_pick #(.DEPTH(DEPTH)) u_pd_pick (
    .clk(clk), .rst_n(rst_n), .hit(pd_hit), .found(pd_found), .idx(pd_idx));

  assign sr_take      = sr_valid && !post_valid;
  assign ev_reply     = sr_take && rx_found;
  assign ev_hold      = sr_take && !rx_found && !pd_full;
  assign ev_sr_busy   = sr_valid && (post_valid || (!rx_found && pd_full));
  assign ev_pull      = post_valid && pd_found;
  assign ev_queue     = post_valid && !pd_found && !rx_full;
  assign ev_post_busy = post_valid && !pd_found && rx_full;

  rdv_table #(.EW(RX_W), .DEPTH(DEPTH)) u_rx_tab (
    .clk(clk), .rst_n(rst_n),
    .push(ev_queue), .push_data({post_wild, post_src, post_tag, post_addr}),
    .pop(ev_reply), .pop_idx(rx_idx),
    .ent(rx_raw), .count(rx_cnt), .full(rx_full));

  rdv_table #(.EW(PD_W), .DEPTH(DEPTH)) u_pd_tab (
    .clk(clk), .rst_n(rst_n),
    .push(ev_hold), .push_data({sr_src, sr_tag, sr_len}),
    .pop(ev_pull), .pop_idx(pd_idx),
    .ent(pd_raw), .count(pd_cnt), .full(pd_full));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      post_done <= 1'b0;
      post_code <= '0;
      sr_busy   <= 1'b0;
      out_valid <= 1'b0;
      out_code  <= '0;
      out_node  <= '0;
      out_tag   <= '0;
      out_addr  <= '0;
      out_len   <= '0;
    end else begin
      post_done <= post_valid;
      post_code <= ev_pull ? PST_MATCHED : (ev_post_busy ? PST_BUSY : PST_QUEUED);
      sr_busy   <= ev_sr_busy;
      out_valid <= ev_reply || ev_hold || ev_pull;
      if (ev_pull) begin
        out_code <= OUT_PULL;
        out_node <= pd_e[pd_idx].src;
        out_tag  <= pd_e[pd_idx].tag;
        out_addr <= post_addr;
        out_len  <= pd_e[pd_idx].len;
      end else begin
        out_code <= ev_reply ? OUT_REPLY : OUT_HELD;
        out_node <= sr_src;
        out_tag  <= sr_tag;
        out_addr <= ev_reply ? rx_e[rx_idx].addr : '0;
        out_len  <= sr_len;
      end
    end
  end

  p_clash_refused_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (post_valid && sr_valid) |=> (sr_busy && post_done));
  p_pull_pairs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_code == OUT_PULL) |-> (post_done && post_code == PST_MATCHED));
  p_busy_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (post_done && post_code == PST_BUSY) |-> $stable(rx_cnt));
  p_held_stored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_code == OUT_HELD) |-> (pd_cnt == $past(pd_cnt) + CW'(1)));
  p_reply_frees_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_code == OUT_REPLY) |-> (rx_cnt == $past(rx_cnt) - CW'(1)));
endmodule

// File: tb/rdv_engine_tb.sv
`timescale 1ns/1ps
module rdv_engine_tb;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        post_valid = 0, post_wild = 0;
  logic [3:0]  post_src = 0;
  logic [7:0]  post_tag = 0;
  logic [15:0] post_addr = 0;
  logic        post_done;
  logic [1:0]  post_code;
  logic        sr_valid = 0;
  logic [3:0]  sr_src = 0;
  logic [7:0]  sr_tag = 0;
  logic [11:0] sr_len = 0;
  logic        sr_busy, out_valid;
  logic [1:0]  out_code;
  logic [3:0]  out_node;
  logic [7:0]  out_tag;
  logic [15:0] out_addr;
  logic [11:0] out_len;

  always #2.5 clk = ~clk;

  rdv_engine u_dut (.*);

  typedef struct { int wild; int src; int tag; int addr; } rx_m;
  typedef struct { int src; int tag; int len; } pd_m;
  rx_m rxq[$];
  pd_m pdq[$];

  int checks = 0, failures = 0;
  bit done = 0;
  int e_ov = 0, e_oc = 0, e_on = 0, e_ot = 0, e_oa = 0, e_ol = 0;
  int e_pd = 0, e_pc = 0, e_sb = 0;
  string lbl = "R10";

  task automatic compare();
    bit bad;
    checks++;
    bad = (out_valid !== 1'(e_ov)) || (post_done !== 1'(e_pd)) || (sr_busy !== 1'(e_sb));
    if (e_ov != 0)
      bad |= (out_code !== 2'(e_oc)) || (out_node !== 4'(e_on)) || (out_tag !== 8'(e_ot)) ||
             (out_addr !== 16'(e_oa)) || (out_len !== 12'(e_ol));
    if (e_pd != 0) bad |= (post_code !== 2'(e_pc));
    if (bad) begin
      failures++;
      $display("FAIL %s t=%0t act ov=%0d oc=%0d on=%0d ot=%0d oa=%0d ol=%0d pd=%0d pc=%0d sb=%0d exp ov=%0d oc=%0d on=%0d ot=%0d oa=%0d ol=%0d pd=%0d pc=%0d sb=%0d",
        lbl, $time, out_valid, out_code, out_node, out_tag, out_addr, out_len, post_done, post_code, sr_busy,
        e_ov, e_oc, e_on, e_ot, e_oa, e_ol, e_pd, e_pc, e_sb);
    end
  endtask

  // one cycle: check last cycle's result, drive new inputs, advance model
  task automatic step(bit pv, bit pw, int ps, int pt, int pa, bit sv, int ss, int st, int sl);
    int hits;
    int j;
    @(negedge clk);
    compare();
    post_valid = pv; post_wild = pw; post_src = 4'(ps); post_tag = 8'(pt); post_addr = 16'(pa);
    sr_valid = sv; sr_src = 4'(ss); sr_tag = 8'(st); sr_len = 12'(sl);
    e_ov = 0; e_pd = 0; e_sb = 0; e_pc = 0; lbl = "idle";
    if (pv) begin
      e_pd = 1; j = -1; hits = 0;
      foreach (pdq[k]) if (pdq[k].tag == pt && (pw || pdq[k].src == ps)) begin
        hits++; if (j < 0) j = k;
      end
      if (j >= 0) begin
        lbl = (hits > 1) ? "R6 R3" : (pw ? "R5 R3" : "R3");
        if (pdq.size() == DEPTH) lbl = {lbl, " R9"};
        e_pc = 1; e_ov = 1; e_oc = 2; e_on = pdq[j].src; e_ot = pdq[j].tag; e_oa = pa; e_ol = pdq[j].len;
        pdq.delete(j);
      end else if (rxq.size() < DEPTH) begin
        lbl = "R4"; e_pc = 0; rxq.push_back('{int'(pw), ps, pt, pa});
      end else begin
        lbl = "R7"; e_pc = 2;
      end
    end
    if (sv) begin
      if (pv) begin
        e_sb = 1; lbl = {lbl, " R8"};
      end else begin
        j = -1; hits = 0;
        foreach (rxq[k]) if (rxq[k].tag == st && (rxq[k].wild != 0 || rxq[k].src == ss)) begin
          hits++; if (j < 0) j = k;
        end
        if (j >= 0) begin
          lbl = (hits > 1) ? "R6 R1" : ((rxq[j].wild != 0) ? "R5 R1" : "R1");
          if (rxq.size() == DEPTH) lbl = {lbl, " R9"};
          e_ov = 1; e_oc = 0; e_on = ss; e_ot = st; e_oa = rxq[j].addr; e_ol = sl;
          rxq.delete(j);
        end else if (pdq.size() < DEPTH) begin
          lbl = "R2"; e_ov = 1; e_oc = 1; e_on = ss; e_ot = st; e_oa = 0; e_ol = sl;
          pdq.push_back('{ss, st, sl});
        end else begin
          lbl = "R7"; e_sb = 1;
        end
      end
    end
  endtask

  task automatic post(bit w, int s, int t, int a); step(1, w, s, t, a, 0, 0, 0, 0); endtask
  task automatic sready(int s, int t, int l);      step(0, 0, 0, 0, 0, 1, s, t, l); endtask
  task automatic idle();                           step(0, 0, 0, 0, 0, 0, 0, 0, 0); endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    idle(); // R10: reset state checked here
    // R4 then R1
    post(0, 3, 5, 100); sready(3, 5, 40); idle();
    // R2 then R3
    sready(1, 2, 9); post(0, 1, 2, 200); idle();
    // R5 both directions
    post(1, 0, 7, 300); sready(9, 7, 11); sready(4, 8, 12); post(1, 0, 8, 301); idle();
    // R5 negative: exact receive does not match another source
    post(0, 2, 9, 310); sready(5, 9, 13); post(0, 5, 9, 311); sready(2, 9, 14); idle();
    // R6 oldest first
    post(0, 2, 1, 400); post(1, 0, 1, 401); sready(2, 1, 15); sready(6, 1, 16); idle();
    // R7 / R9 receive store full
    for (int i = 0; i < DEPTH; i++) post(0, 1, 20 + i, 500 + i);
    post(0, 1, 99, 600); sready(1, 23, 17); post(0, 1, 99, 601);
    for (int i = 0; i < DEPTH; i++) sready(1, (i == 3) ? 99 : 20 + i, 18);
    // R7 / R9 pending store full
    for (int i = 0; i < DEPTH; i++) sready(2, 40 + i, 30 + i);
    sready(2, 77, 50); post(0, 2, 44, 700); sready(2, 77, 51);
    for (int i = 0; i < DEPTH; i++) post(0, 2, (i == 4) ? 77 : 40 + i, 710 + i);
    // R8 clash
    step(1, 0, 3, 3, 800, 1, 3, 3, 60); step(0, 0, 0, 0, 0, 1, 3, 3, 61); idle();
    // mixed random traffic
    for (int c = 0; c < 4000; c++) begin
      int r = $urandom_range(0, 9);
      step(r inside {[0:3]} || r == 8, $urandom_range(0, 4) == 0, $urandom_range(0, 3), $urandom_range(0, 3),
           $urandom_range(0, 65535), r inside {[4:8]}, $urandom_range(0, 3), $urandom_range(0, 3),
           $urandom_range(0, 4095));
    end
    idle(); idle();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule